// File: doc/BRIEF.md
# TDM Time Slot Routing Engine

This block cuts a time-division-multiplexed serial line into slots and hands each slot to one of four serial channels, or to none of them. Two routing tables, one for the receive direction and one for the transmit direction, each hold an ordered list of slot entries. Each entry gives a channel code, a slot length, a pair of strobe bits and an end-of-frame flag. A frame begins with a frame sync pulse. Each table's sequencer then walks its entries one bit at a time until it meets the entry marked as the last one.

Receive data and frame sync are taken on the falling edge of the bit clock. Transmit data is launched on the rising edge, so the far end can take it on the next falling edge. The transmit pin has an output enable. The enable is high only during bits that the transmit table routes to a channel, and the pin floats at all other times. A grant input is captured together with the frame sync and passed to the channel that carries the signalling (D) channel. Software fills the tables through a simple write port. A write lands in a staging copy, which becomes live only when the next frame sync arrives.

Each sequencer is a two-state machine. SEQ_IDLE waits for a sync. SEQ_RUN counts bits through the entries. The transitions are:
- SYNC_START: SEQ_IDLE to SEQ_RUN, taken on a sampled sync.
- RESYNC: SEQ_RUN to SEQ_RUN at entry 0, taken on a sync that arrives mid-frame.
- SLOT_ADVANCE: SEQ_RUN to SEQ_RUN at the next entry, taken when a slot's last bit passes.
- FRAME_END: SEQ_RUN to SEQ_IDLE, taken when the last bit of an entry flagged as last passes, or the last bit of the final table row.

Top module: `tdm_slot_router`

## Requirements
- R1: After reset, all channel strobes, slot strobes, transmit requests and grants are 0, and the transmit output enable is 0.
- R2: A sync sampled at a falling edge makes the next falling edge sample bit 0 of entry 0. The sampled receive bit appears on rx_bit in the same edge as the channel strobe.
- R3: An entry's channel code (bits [2:0]) with value k from 1 to 4 routes the slot to channel k, which is bit k-1 of the per-channel vectors. Codes 0 and 5 to 7 route the slot to no channel.
- R4: An entry's length is count+1 bits when its unit flag (bit 7) is 0, and (count+1)×8 bits when the flag is 1. The count is held in bits [6:3].
- R5: While a routed or unrouted slot is active, the entry's strobe bits (bits [11:8]) appear on the receive or transmit slot strobe output of its direction.
- R6: On the rising edge, txd takes the ch_tx_data bit of the channel that the transmit table selects, and ch_tx_req marks that channel.
- R7: txd_oe is 1 only for bits that the transmit table routes to a channel. It is 0 for unrouted bits, for idle time and for the sync bit.
- R8: When the last bit of an entry with the last flag (bit 12) set passes, the sequencer idles with no strobes and the transmitter floats until a sync arrives.
- R9: A sync that arrives before the frame ends restarts both tables at entry 0.
- R10: Write addresses below 128 load the receive table and addresses from 128 load the transmit table, each at index addr mod 128. The two tables route independently.
- R11: grant_in is captured only on a sync edge and is shown on the D-channel bit of ch_grant, which is channel 1 by default. ch_grant holds this value between syncs.
- R12: A table write takes effect only from the next sync. The frame in progress uses the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, sampled on the falling edge |
| rxd | input | 1 | Serial receive data, sampled on the falling edge |
| grant_in | input | 1 | Grant line, sampled together with the sync |
| tbl_we | input | 1 | Table write strobe, taken on the rising edge |
| tbl_addr | input | 8 | Table write address; bit 7 selects the transmit table |
| tbl_wdata | input | 13 | Entry to write |
| ch_tx_data | input | 4 | Next transmit bit from each channel |
| ch_rx_stb | output | 4 | Per-channel receive bit valid |
| rx_bit | output | 1 | Receive bit sampled at the last falling edge |
| rx_slot_strb | output | 4 | Strobe bits of the active receive entry |
| ch_tx_req | output | 4 | Per-channel transmit bit consumed |
| txd | output | 1 | Transmit data |
| txd_oe | output | 1 | Transmit output enable |
| tx_slot_strb | output | 4 | Strobe bits of the active transmit entry |
| ch_grant | output | 4 | Grant indication to the D-channel controller |

## Verification
If the bit counter or the entry index is off, the strobes shift by whole bits, and a channel's strobe appears in the wrong bit position right after the first slot of a frame. The bench checks every bit against positions it computes from the tables. A sequencer that fails to reach SEQ_IDLE shows up as strobes or a raised txd_oe in the idle bits that follow the last entry. A missed restart shows up in the first bit after a mid-frame sync. A table that takes a write too early changes the routing inside the frame in progress, and the change is visible within the same frame.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    parameter int NCH    = 4;
    parameter int CSEL_W = 3;
    parameter int CNT_W  = 4;
    parameter int STB_W  = 4;
    localparam int LEN_W = CNT_W + 3;

    typedef struct packed {
        logic             last;
        logic [STB_W-1:0] stb;
        logic             unit_byte;
        logic [CNT_W-1:0] cnt;
        logic [CSEL_W-1:0] csel;
    } slot_entry_t;

    localparam int ENTRY_W = $bits(slot_entry_t);

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

    function automatic logic [NCH-1:0] chan_decode(input logic [CSEL_W-1:0] code);
        logic [NCH-1:0] hot;
        for (int k = 0; k < NCH; k++) begin
            hot[k] = (code == CSEL_W'(k + 1));
        end
        return hot;
    endfunction
endpackage

// File: rtl/tdm_route_table.sv
module tdm_route_table
    import tdm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_entry_t      wr_data,
    input  logic             commit,
    input  logic [IDX_W-1:0] rd_idx,
    output slot_entry_t      rd_entry
);
    slot_entry_t staged [DEPTH];
    slot_entry_t live   [DEPTH];

    // Staging copy: written by software on the rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) staged[i] <= '0;
        end else if (wr_en) begin
            staged[wr_idx] <= wr_data;
        end
    end

    // Live copy: swapped in whole at a frame boundary (sampled sync).
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) live[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < DEPTH; i++) live[i] <= staged[i];
        end
    end

    assign rd_entry = live[rd_idx];
endmodule

// File: rtl/tdm_seq.sv
module tdm_seq
    import tdm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  slot_entry_t      ent,
    output logic [IDX_W-1:0] idx,
    output logic             active,
    output logic [NCH-1:0]   chan,
    output logic [STB_W-1:0] stb
);
    seq_state_e       state, state_nx;
    logic [LEN_W-1:0] bitcnt;
    logic [LEN_W-1:0] len_m1;
    logic             last_bit;
    logic             wrap;

    assign len_m1   = ent.unit_byte ? {ent.cnt, 3'b111} : {3'b000, ent.cnt};
    assign last_bit = (bitcnt == len_m1);
    assign wrap     = ent.last || (idx == IDX_W'(DEPTH - 1));

    // Next-state: SYNC_START, RESYNC, SLOT_ADVANCE, FRAME_END
    always_comb begin
        state_nx = state;
        if (fsync) begin
            state_nx = SEQ_RUN;
        end else begin
            unique case (state)
                SEQ_IDLE: state_nx = SEQ_IDLE;
                SEQ_RUN:  state_nx = (last_bit && wrap) ? SEQ_IDLE : SEQ_RUN;
            endcase
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            bitcnt <= '0;
        end else if (fsync) begin
            idx    <= '0;
            bitcnt <= '0;
        end else if (state == SEQ_RUN) begin
            if (last_bit) begin
                bitcnt <= '0;
                idx    <= wrap ? '0 : idx + 1'b1;
            end else begin
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    // Outputs per state
    always_comb begin
        unique case (state)
            SEQ_IDLE: begin
                active = 1'b0;
                chan   = '0;
                stb    = '0;
            end
            SEQ_RUN: begin
                active = 1'b1;
                chan   = chan_decode(ent.csel);
                stb    = ent.stb;
            end
        endcase
    end

    // R2
    sync_start_chk: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(fsync) && $past(rst_n)) |-> (state == SEQ_RUN && idx == '0 && bitcnt == '0));
    // R8
    frame_end_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (state == SEQ_RUN && !fsync && last_bit && ent.last) |=> (state == SEQ_IDLE));
    // R8
    idle_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && !fsync) |=> (state == SEQ_IDLE && bitcnt == '0));
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
    import tdm_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 8,
    parameter int D_CHAN = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fsync,
    input  logic               rxd,
    input  logic               grant_in,
    input  logic               tbl_we,
    input  logic [ADDR_W-1:0]  tbl_addr,
    input  logic [ENTRY_W-1:0] tbl_wdata,
    input  logic [NCH-1:0]     ch_tx_data,
    output logic [NCH-1:0]     ch_rx_stb,
    output logic               rx_bit,
    output logic [STB_W-1:0]   rx_slot_strb,
    output logic [NCH-1:0]     ch_tx_req,
    output logic               txd,
    output logic               txd_oe,
    output logic [STB_W-1:0]   tx_slot_strb,
    output logic [NCH-1:0]     ch_grant
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [NCH-1:0] DMASK = NCH'(1) << (D_CHAN - 1);

    logic             wr_ok;
    logic [1:0]       tbl_we_dir;
    slot_entry_t      ent   [2];
    logic [IDX_W-1:0] idx   [2];
    logic             act   [2];
    logic [NCH-1:0]   chan  [2];
    logic [STB_W-1:0] stb   [2];

    assign wr_ok      = tbl_we && (tbl_addr[ADDR_W-2:0] < (ADDR_W-1)'(DEPTH));
    assign tbl_we_dir = {wr_ok && tbl_addr[ADDR_W-1], wr_ok && !tbl_addr[ADDR_W-1]};

    // Direction 0 = receive table, direction 1 = transmit table
    for (genvar d = 0; d < 2; d++) begin : g_dir
        tdm_route_table #(.DEPTH(DEPTH)) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (tbl_we_dir[d]),
            .wr_idx   (tbl_addr[IDX_W-1:0]),
            .wr_data  (slot_entry_t'(tbl_wdata)),
            .commit   (fsync),
            .rd_idx   (idx[d]),
            .rd_entry (ent[d])
        );
        tdm_seq #(.DEPTH(DEPTH)) u_seq (
            .clk    (clk),
            .rst_n  (rst_n),
            .fsync  (fsync),
            .ent    (ent[d]),
            .idx    (idx[d]),
            .active (act[d]),
            .chan   (chan[d]),
            .stb    (stb[d])
        );
    end

    // Receive side and grant: falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_rx_stb    <= '0;
            rx_bit       <= 1'b0;
            rx_slot_strb <= '0;
            ch_grant     <= '0;
        end else begin
            ch_rx_stb    <= chan[0];
            rx_bit       <= rxd;
            rx_slot_strb <= act[0] ? stb[0] : '0;
            if (fsync) ch_grant <= grant_in ? DMASK : '0;
        end
    end

    // Transmit side: rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd          <= 1'b0;
            txd_oe       <= 1'b0;
            ch_tx_req    <= '0;
            tx_slot_strb <= '0;
        end else begin
            txd          <= |(chan[1] & ch_tx_data);
            txd_oe       <= |chan[1];
            ch_tx_req    <= chan[1];
            tx_slot_strb <= act[1] ? stb[1] : '0;
        end
    end

    // R3
    rx_onehot_chk: assert property (@(negedge clk) disable iff (!rst_n)
        $onehot0(ch_rx_stb));
    // R7
    tx_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan[1] == '0) |=> !txd_oe);
    // R11
    grant_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fsync)) |-> $stable(ch_grant));
endmodule

// File: tb/test_tdm_slot_router.sv
module test_tdm_slot_router;
    import tdm_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               fsync = 1'b0, rxd = 1'b0, grant_in = 1'b0, tbl_we = 1'b0;
    logic [7:0]         tbl_addr = '0;
    logic [ENTRY_W-1:0] tbl_wdata = '0;
    logic [3:0]         ch_tx_data = '0;
    logic [3:0]         ch_rx_stb, rx_slot_strb, ch_tx_req, tx_slot_strb, ch_grant;
    logic               rx_bit, txd, txd_oe;

    tdm_slot_router i_tdm_slot_router (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .rxd(rxd), .grant_in(grant_in),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .ch_tx_data(ch_tx_data), .ch_rx_stb(ch_rx_stb), .rx_bit(rx_bit),
        .rx_slot_strb(rx_slot_strb), .ch_tx_req(ch_tx_req), .txd(txd),
        .txd_oe(txd_oe), .tx_slot_strb(tx_slot_strb), .ch_grant(ch_grant)
    );

    always #10 clk = ~clk;

    typedef struct { logic [3:0] ch; logic b; logic [3:0] st; logic [3:0] g; string ph; } rx_item_t;
    typedef struct { logic [3:0] ch; logic b; logic [3:0] st; string ph; } tx_item_t;
    rx_item_t    rxq[$];
    tx_item_t    txq[$];
    slot_entry_t sh_rx[16], ac_rx[16], sh_tx[16], ac_tx[16];
    int          cur_rx = -1, cur_tx = -1;
    logic [3:0]  g_exp = '0;
    int          checks = 0, fails = 0;
    bit          pend_we = 0;
    logic [7:0]  pend_addr = '0;
    slot_entry_t pend_data = '0;

    function automatic slot_entry_t mk(int csel, int cnt, bit by, int st, bit last);
        slot_entry_t e;
        e.csel = 3'(csel); e.cnt = 4'(cnt); e.unit_byte = by; e.stb = 4'(st); e.last = last;
        return e;
    endfunction

    function automatic slot_entry_t get(bit tx, int i);
        return tx ? ac_tx[i] : ac_rx[i];
    endfunction

    function automatic int ent_len(slot_entry_t e);
        return e.unit_byte ? (int'(e.cnt) + 1) * 8 : int'(e.cnt) + 1;
    endfunction

    function automatic int flen(bit tx);
        int acc = 0;
        for (int i = 0; i < 16; i++) begin
            acc += ent_len(get(tx, i));
            if (get(tx, i).last) break;
        end
        return acc;
    endfunction

    function automatic void look(bit tx, int slot, output logic [3:0] ch, output logic [3:0] st);
        int acc = 0;
        ch = '0; st = '0;
        if (slot < 0) return;
        for (int i = 0; i < 16; i++) begin
            slot_entry_t e = get(tx, i);
            if (slot < acc + ent_len(e)) begin
                ch = (e.csel >= 1 && e.csel <= 4) ? 4'(1 << (e.csel - 1)) : 4'b0;
                st = e.stb;
                return;
            end
            acc += ent_len(e);
            if (e.last) return;
        end
    endfunction

    task automatic chk(string req, string ph, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (phase %s) actual=%h expected=%h at %0t", req, ph, act, exp, $time);
        end
    endtask

    task automatic wr(int addr, slot_entry_t e);
        pend_we = 1; pend_addr = 8'(addr); pend_data = e;
    endtask

    // Driver: drives one bit and pushes the expected results
    task automatic drive_bit(bit fs, bit gr, string ph);
        bit         r;
        logic [3:0] td, ch, st;
        int         nx;
        @(posedge clk); #2;
        r = 1'($urandom); td = 4'($urandom);
        fsync = fs; rxd = r; grant_in = gr; ch_tx_data = td;
        tbl_we = pend_we; tbl_addr = pend_addr; tbl_wdata = pend_data;
        look(0, cur_rx, ch, st);
        if (fs) g_exp = gr ? 4'b0001 : 4'b0000;
        rxq.push_back('{ch, r, st, g_exp, ph});
        nx = fs ? 0 : ((cur_rx >= 0 && cur_rx + 1 < flen(0)) ? cur_rx + 1 : -1);
        cur_rx = nx;
        if (fs) begin ac_rx = sh_rx; ac_tx = sh_tx; end
        if (pend_we) begin
            if (pend_addr[7]) sh_tx[pend_addr[3:0]] = pend_data;
            else              sh_rx[pend_addr[3:0]] = pend_data;
            pend_we = 0;
        end
        nx = fs ? 0 : ((cur_tx >= 0 && cur_tx + 1 < flen(1)) ? cur_tx + 1 : -1);
        cur_tx = nx;
        look(1, cur_tx, ch, st);
        txq.push_back('{ch, |(ch & td), st, ph});
    endtask

    // Monitor: receive results after each falling edge
    always @(negedge clk) begin
        rx_item_t it;
        #5;
        if (rxq.size() > 0) begin
            it = rxq.pop_front();
            chk("R3 R4", it.ph, ch_rx_stb, it.ch);
            if (it.ch != 0) chk("R2", it.ph, {3'b0, rx_bit}, {3'b0, it.b});
            chk("R5", it.ph, rx_slot_strb, it.st);
            chk("R11", it.ph, ch_grant, it.g);
        end
    end

    // Monitor: transmit results after each rising edge
    always @(posedge clk) begin
        tx_item_t it;
        #5;
        if (txq.size() >= 2) begin
            it = txq.pop_front();
            chk("R7", it.ph, {3'b0, txd_oe}, {3'b0, |it.ch});
            chk("R6", it.ph, ch_tx_req, it.ch);
            if (|it.ch) chk("R6", it.ph, {3'b0, txd}, {3'b0, it.b});
            chk("R5", it.ph, tx_slot_strb, it.st);
        end
    end

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        slot_entry_t ex[5];
        for (int i = 0; i < 16; i++) begin sh_rx[i] = '0; sh_tx[i] = '0; ac_rx[i] = '0; ac_tx[i] = '0; end
        ex[0] = mk(1, 0, 0, 1, 0);
        ex[1] = mk(0, 0, 0, 0, 0);
        ex[2] = mk(2, 0, 1, 0, 0);
        ex[3] = mk(4, 0, 1, 2, 0);
        ex[4] = mk(1, 0, 0, 4, 1);
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        @(negedge clk); #5;
        // R1 reset state
        chk("R1", "reset", ch_rx_stb, 4'b0);
        chk("R1", "reset", {3'b0, txd_oe}, 4'b0);
        chk("R1", "reset", ch_grant, 4'b0);
        chk("R1", "reset", ch_tx_req, 4'b0);
        chk("R1", "reset", rx_slot_strb | tx_slot_strb, 4'b0);
        // R10 load both tables
        for (int i = 0; i < 5; i++) begin wr(i, ex[i]); drive_bit(0, 0, "R10"); end
        for (int i = 0; i < 5; i++) begin wr(128 + i, ex[i]); drive_bit(0, 0, "R10"); end
        // Example frame, then idle after the last entry (R8)
        drive_bit(1, 1, "R2");
        repeat (19) drive_bit(0, 0, "R4");
        repeat (4) drive_bit(0, 1, "R8");
        // R10 transmit table differs: 16 bits to channel 3
        wr(128, mk(3, 1, 1, 2, 1));
        drive_bit(0, 0, "R10");
        // R12 mid-frame write to the receive table
        drive_bit(1, 0, "R12");
        repeat (3) drive_bit(0, 0, "R12");
        wr(2, mk(3, 2, 0, 8, 0));
        repeat (24) drive_bit(0, 0, "R12");
        drive_bit(1, 1, "R12");
        repeat (5) drive_bit(0, 0, "R12");
        // R9 early sync restarts
        drive_bit(1, 0, "R9");
        repeat (25) drive_bit(0, 0, "R9");
        repeat (3) drive_bit(0, 0, "R8");
        repeat (3) @(posedge clk);
        #8;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule